// File: doc/BRIEF.md
# Tag-Renaming Reservation Station Scheduler

This block is a dynamic instruction scheduler. Each cycle it accepts at most one instruction and places it in a free reservation station of the instruction's class: arithmetic (class 0) or memory (class 1). At that moment each source operand is either copied as a value or, when its producer has not finished yet, replaced by that producer's station tag. The destination register is then pointed at the issuing station's tag. Because of this renaming, a later write to the same register or a write to a register that an older instruction still has to read never holds up issue.

A station whose operands are all present offers itself to the external functional unit of its class on a dispatch port. Arithmetic stations may start in any order. Memory stations start strictly in program order. When a unit finishes, it requests the single result bus. One request is granted per cycle, and one cycle later the result appears on the bus. Every station waiting on that tag, and the internal register file, take the value from the bus in the same cycle. The station that owns the tag becomes free in that cycle.

Issue, dispatch and completion are valid/ready streams. Issue: `iss_ready` depends only on `iss_cls` and station occupancy, never on `iss_valid`, and the instruction is taken on a clock edge with both high. Dispatch: once `disp_valid[c]` is high, the payload on that slice holds until `disp_ready[c]` accepts it. Completion: `done_ready[c]` is the bus grant, and a unit keeps `done_valid[c]` and its payload steady until it is granted.

Top module: `rs_sched`

## Requirements
- R1: After reset every station is free, `iss_ready` is high for both classes, no dispatch or bus output is valid, and architectural register k holds the value k.
- R2: An operand whose register has no pending producer is copied at issue. The dispatch slice of the class (slice c is bits `[c*W +: W]`) shows the op code, both operand values and the station tag. Arithmetic stations carry tags 0..N_ARITH-1 and memory stations carry N_ARITH..N_ARITH+N_MEM-1.
- R3: An operand with a pending producer records that producer's tag. The station does not dispatch until the tag is broadcast, and it then dispatches with the broadcast value.
- R4: Issue renames the destination register to the new station's tag. A broadcast of an older tag neither updates that register nor wakes readers of the newer tag.
- R5: A value broadcast in the same cycle as an issue that reads its tag is taken directly by the issuing instruction, which needs no later wake-up.
- R6: Among ready arithmetic stations, the lowest-numbered one is offered first.
- R7: Memory stations start in issue order. A younger ready memory station waits behind an older one that is not ready.
- R8: At most one completion is granted per cycle, and class 0 beats class 1. A request that is not granted stays pending and is granted later.
- R9: A result granted on one clock edge is driven on `cdb_valid`/`cdb_tag`/`cdb_value` for the following cycle.
- R10: `iss_ready` is low for a class whose next free station does not exist. For the memory class this means the slot at its ring position is still busy.
- R11: While `disp_valid[c]` is high and not accepted, the offered station does not change, even if a lower-numbered station becomes ready.
- R12: A station is released in the cycle its tag is broadcast and can be reused from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Instruction offered |
| iss_ready | output | 1 | Station of class `iss_cls` available |
| iss_cls | input | 1 | 0 arithmetic, 1 memory |
| iss_op | input | OP_W | Operation code carried to the unit |
| iss_dst | input | REG_W | Destination register |
| iss_srca | input | REG_W | First source register |
| iss_srcb | input | REG_W | Second source register |
| disp_valid | output | 2 | Per class: station offered to unit |
| disp_ready | input | 2 | Per class: unit accepts |
| disp_op | output | 2*OP_W | Per class op code |
| disp_tag | output | 2*TAG_W | Per class station tag |
| disp_a | output | 2*DATA_W | Per class first operand |
| disp_b | output | 2*DATA_W | Per class second operand |
| done_valid | input | 2 | Per class: unit requests the bus |
| done_ready | output | 2 | Per class: bus grant |
| done_tag | input | 2*TAG_W | Per class tag of finished result |
| done_value | input | 2*DATA_W | Per class result value |
| cdb_valid | output | 1 | Broadcast valid |
| cdb_tag | output | TAG_W | Broadcast tag |
| cdb_value | output | DATA_W | Broadcast value |

## Verification
The scheduler is driven with operands that are ready at issue, operands waiting on one producer, two writers of the same register followed by a reader, and a reader issued in the very cycle its producer broadcasts. Together these separate copying at issue, tag wake-up, rename overwrite and the same-cycle bypass. A memory pair whose older member waits shows ordered start, as opposed to the any-order start of arithmetic stations. Simultaneous completions expose the grant priority and the holding of the loser. A held offer with a lower station becoming ready shows that dispatch payloads stay stable. Filling a class and then draining one station shows the issue stall and its release.

// File: rtl/rs_sched_pkg.sv
package rs_sched_pkg;
  localparam int NCLS = 2;
  typedef enum logic {CLS_ARITH = 1'b0, CLS_MEM = 1'b1} cls_e;
endpackage

// File: rtl/rs_regstat.sv
// Register values plus rename status; two read ports with bus bypass.
module rs_regstat #(
  parameter int NREG   = 8,
  parameter int DATA_W = 16,
  parameter int TAG_W  = 2,
  localparam int REG_W = $clog2(NREG)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [1:0][REG_W-1:0]       rd_idx,
  output logic [1:0]                  rd_rdy,
  output logic [1:0][DATA_W-1:0]      rd_val,
  output logic [1:0][TAG_W-1:0]       rd_tag,
  input  logic                        ren_en,
  input  logic [REG_W-1:0]            ren_idx,
  input  logic [TAG_W-1:0]            ren_tag,
  input  logic                        bus_valid,
  input  logic [TAG_W-1:0]            bus_tag,
  input  logic [DATA_W-1:0]           bus_value
);
  logic [DATA_W-1:0] rf   [NREG];
  logic [TAG_W-1:0]  rtag [NREG];
  logic [NREG-1:0]   pend;

  always_comb begin
    for (int p = 0; p < 2; p++) begin
      rd_tag[p] = rtag[rd_idx[p]];
      if (!pend[rd_idx[p]]) begin
        rd_rdy[p] = 1'b1;
        rd_val[p] = rf[rd_idx[p]];
      end else if (bus_valid && rtag[rd_idx[p]] == bus_tag) begin
        rd_rdy[p] = 1'b1;
        rd_val[p] = bus_value;
      end else begin
        rd_rdy[p] = 1'b0;
        rd_val[p] = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      for (int r = 0; r < NREG; r++) begin
        rf[r]   <= DATA_W'(r);
        rtag[r] <= '0;
      end
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (bus_valid && pend[r] && rtag[r] == bus_tag) begin
          rf[r]   <= bus_value;
          pend[r] <= 1'b0;
        end
        if (ren_en && ren_idx == REG_W'(r)) begin
          pend[r] <= 1'b1;
          rtag[r] <= ren_tag;
        end
      end
    end
  end
endmodule

// File: rtl/rs_pick.sv
// Lowest-index selection that holds its choice until accepted.
module rs_pick #(
  parameter int N  = 2,
  parameter int IW = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          fire,
  output logic          sel_valid,
  output logic [IW-1:0] sel_idx
);
  logic          held;
  logic [IW-1:0] held_idx;

  always_comb begin
    sel_valid = 1'b0;
    sel_idx   = '0;
    if (held) begin
      sel_valid = 1'b1;
      sel_idx   = held_idx;
    end else begin
      for (int k = N - 1; k >= 0; k--) begin
        if (req[k]) begin
          sel_valid = 1'b1;
          sel_idx   = IW'(k);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held     <= 1'b0;
      held_idx <= '0;
    end else begin
      held     <= sel_valid && !fire;
      held_idx <= sel_idx;
    end
  end
endmodule

// File: rtl/rs_cdb_arb.sv
// Fixed-priority grant of the result bus, registered broadcast.
module rs_cdb_arb #(
  parameter int NREQ   = 2,
  parameter int TAG_W  = 2,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NREQ-1:0]          req_valid,
  input  logic [NREQ*TAG_W-1:0]    req_tag,
  input  logic [NREQ*DATA_W-1:0]   req_value,
  output logic [NREQ-1:0]          grant,
  output logic                     bus_valid,
  output logic [TAG_W-1:0]         bus_tag,
  output logic [DATA_W-1:0]        bus_value
);
  logic [TAG_W-1:0]  win_tag;
  logic [DATA_W-1:0] win_value;

  always_comb begin
    grant     = '0;
    win_tag   = '0;
    win_value = '0;
    for (int k = NREQ - 1; k >= 0; k--) begin
      if (req_valid[k]) begin
        grant     = '0;
        grant[k]  = 1'b1;
        win_tag   = req_tag[k*TAG_W +: TAG_W];
        win_value = req_value[k*DATA_W +: DATA_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_valid <= 1'b0;
      bus_tag   <= '0;
      bus_value <= '0;
    end else begin
      bus_valid <= |req_valid;
      bus_tag   <= win_tag;
      bus_value <= win_value;
    end
  end
endmodule

// File: rtl/rs_sched.sv
module rs_sched
  import rs_sched_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int NREG    = 8,
  parameter int OP_W    = 4,
  parameter int N_ARITH = 2,
  parameter int N_MEM   = 2,
  localparam int NRS    = N_ARITH + N_MEM,
  localparam int TAG_W  = $clog2(NRS),
  localparam int REG_W  = $clog2(NREG)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     iss_valid,
  output logic                     iss_ready,
  input  logic                     iss_cls,
  input  logic [OP_W-1:0]          iss_op,
  input  logic [REG_W-1:0]         iss_dst,
  input  logic [REG_W-1:0]         iss_srca,
  input  logic [REG_W-1:0]         iss_srcb,
  output logic [NCLS-1:0]          disp_valid,
  input  logic [NCLS-1:0]          disp_ready,
  output logic [NCLS*OP_W-1:0]     disp_op,
  output logic [NCLS*TAG_W-1:0]    disp_tag,
  output logic [NCLS*DATA_W-1:0]   disp_a,
  output logic [NCLS*DATA_W-1:0]   disp_b,
  input  logic [NCLS-1:0]          done_valid,
  output logic [NCLS-1:0]          done_ready,
  input  logic [NCLS*TAG_W-1:0]    done_tag,
  input  logic [NCLS*DATA_W-1:0]   done_value,
  output logic                     cdb_valid,
  output logic [TAG_W-1:0]         cdb_tag,
  output logic [DATA_W-1:0]        cdb_value
);
  localparam int MP_W = (N_MEM > 1) ? $clog2(N_MEM) : 1;

  // station state
  logic [NRS-1:0]    busy, sent, wa, wb, rdy;
  logic [TAG_W-1:0]  ta [NRS];
  logic [TAG_W-1:0]  tb [NRS];
  logic [DATA_W-1:0] va [NRS];
  logic [DATA_W-1:0] vb [NRS];
  logic [OP_W-1:0]   op [NRS];

  logic [MP_W-1:0]   mem_wr, mem_rd;
  logic              is_mem, ar_free, iss_fire;
  logic [TAG_W-1:0]  ar_idx, mem_slot, alloc_idx;
  logic [NCLS-1:0]   fire;
  logic [TAG_W-1:0]  fire_tag [NCLS];

  logic [1:0]              rd_rdy;
  logic [1:0][DATA_W-1:0]  rd_val;
  logic [1:0][TAG_W-1:0]   rd_tag;

  assign rdy = busy & ~sent & ~wa & ~wb;

  // allocation
  always_comb begin
    ar_free = 1'b0;
    ar_idx  = '0;
    for (int i = N_ARITH - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        ar_free = 1'b1;
        ar_idx  = TAG_W'(i);
      end
    end
    is_mem    = (cls_e'(iss_cls) == CLS_MEM);
    mem_slot  = TAG_W'(N_ARITH) + TAG_W'(mem_wr);
    iss_ready = is_mem ? !busy[mem_slot] : ar_free;
    alloc_idx = is_mem ? mem_slot : ar_idx;
  end
  assign iss_fire = iss_valid && iss_ready;

  rs_regstat #(.NREG(NREG), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_regstat (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_idx    ({iss_srcb, iss_srca}),
    .rd_rdy    (rd_rdy),
    .rd_val    (rd_val),
    .rd_tag    (rd_tag),
    .ren_en    (iss_fire),
    .ren_idx   (iss_dst),
    .ren_tag   (alloc_idx),
    .bus_valid (cdb_valid),
    .bus_tag   (cdb_tag),
    .bus_value (cdb_value)
  );

  rs_cdb_arb #(.NREQ(NCLS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (done_valid),
    .req_tag   (done_tag),
    .req_value (done_value),
    .grant     (done_ready),
    .bus_valid (cdb_valid),
    .bus_tag   (cdb_tag),
    .bus_value (cdb_value)
  );

  // per-class dispatch selection
  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    localparam int BASE = (c == 0) ? 0 : N_ARITH;
    localparam int CNT  = (c == 0) ? N_ARITH : N_MEM;
    localparam int IW   = (CNT > 1) ? $clog2(CNT) : 1;
    logic [CNT-1:0]   req;
    logic             sel_v;
    logic [IW-1:0]    sel_i;
    logic [TAG_W-1:0] gidx;

    if (c == 0) begin : g_any
      assign req = rdy[BASE +: CNT];
    end else begin : g_inorder
      always_comb begin
        req         = '0;
        req[mem_rd] = rdy[N_ARITH + int'(mem_rd)];
      end
    end

    rs_pick #(.N(CNT), .IW(IW)) u_pick (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req),
      .fire      (fire[c]),
      .sel_valid (sel_v),
      .sel_idx   (sel_i)
    );

    assign gidx        = TAG_W'(BASE) + TAG_W'(sel_i);
    assign disp_valid[c] = sel_v;
    assign fire[c]     = sel_v && disp_ready[c];
    assign fire_tag[c] = gidx;
    assign disp_op[c*OP_W +: OP_W]     = op[gidx];
    assign disp_tag[c*TAG_W +: TAG_W]  = gidx;
    assign disp_a[c*DATA_W +: DATA_W]  = va[gidx];
    assign disp_b[c*DATA_W +: DATA_W]  = vb[gidx];
  end

  // memory ring pointers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_wr <= '0;
      mem_rd <= '0;
    end else begin
      if (iss_fire && is_mem)
        mem_wr <= (mem_wr == MP_W'(N_MEM - 1)) ? '0 : mem_wr + 1'b1;
      if (fire[1])
        mem_rd <= (mem_rd == MP_W'(N_MEM - 1)) ? '0 : mem_rd + 1'b1;
    end
  end

  // station update: release, wake-up, dispatch, issue
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= '0;
      sent <= '0;
      wa   <= '0;
      wb   <= '0;
      for (int i = 0; i < NRS; i++) begin
        ta[i] <= '0;
        tb[i] <= '0;
        va[i] <= '0;
        vb[i] <= '0;
        op[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NRS; i++) begin
        if (cdb_valid && cdb_tag == TAG_W'(i))
          busy[i] <= 1'b0;
        if (busy[i] && wa[i] && cdb_valid && ta[i] == cdb_tag) begin
          va[i] <= cdb_value;
          wa[i] <= 1'b0;
        end
        if (busy[i] && wb[i] && cdb_valid && tb[i] == cdb_tag) begin
          vb[i] <= cdb_value;
          wb[i] <= 1'b0;
        end
        for (int c = 0; c < NCLS; c++)
          if (fire[c] && fire_tag[c] == TAG_W'(i))
            sent[i] <= 1'b1;
        if (iss_fire && alloc_idx == TAG_W'(i)) begin
          busy[i] <= 1'b1;
          sent[i] <= 1'b0;
          op[i]   <= iss_op;
          wa[i]   <= !rd_rdy[0];
          ta[i]   <= rd_tag[0];
          va[i]   <= rd_val[0];
          wb[i]   <= !rd_rdy[1];
          tb[i]   <= rd_tag[1];
          vb[i]   <= rd_val[1];
        end
      end
    end
  end
endmodule

// File: rtl/rs_sched_check.sv
module rs_sched_check #(
  parameter int TAG_W   = 2,
  parameter int N_ARITH = 2,
  parameter int N_MEM   = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         done_valid,
  input logic [1:0]         done_ready,
  input logic               cdb_valid,
  input logic [1:0]         disp_valid,
  input logic [1:0]         disp_ready,
  input logic [2*TAG_W-1:0] disp_tag
);
  logic [TAG_W-1:0] exp_mem;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      exp_mem <= TAG_W'(N_ARITH);
    else if (disp_valid[1] && disp_ready[1])
      exp_mem <= (exp_mem == TAG_W'(N_ARITH + N_MEM - 1)) ? TAG_W'(N_ARITH) : exp_mem + 1'b1;
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done_ready)); // R8
  AST_GRANT_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    done_ready[1] |-> !done_valid[0]); // R8
  AST_BUS_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (|(done_valid & done_ready)) |=> cdb_valid); // R9
  AST_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(|done_valid) |=> !cdb_valid); // R9
  AST_HOLD_ARITH: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid[0] && !disp_ready[0]) |=> (disp_valid[0] && $stable(disp_tag[TAG_W-1:0]))); // R11
  AST_HOLD_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid[1] && !disp_ready[1]) |=> (disp_valid[1] && $stable(disp_tag[2*TAG_W-1:TAG_W]))); // R11
  AST_MEM_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid[1] && disp_ready[1]) |-> disp_tag[2*TAG_W-1:TAG_W] == exp_mem); // R7
endmodule

bind rs_sched rs_sched_check #(.TAG_W(TAG_W), .N_ARITH(N_ARITH), .N_MEM(N_MEM)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .done_valid (done_valid),
  .done_ready (done_ready),
  .cdb_valid  (cdb_valid),
  .disp_valid (disp_valid),
  .disp_ready (disp_ready),
  .disp_tag   (disp_tag)
);

// File: tb/tb_rs_sched.sv
module tb_rs_sched;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int OW = 4;
  localparam int TW = 2;
  localparam int RW = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic iss_valid, iss_ready, iss_cls;
  logic [OW-1:0] iss_op;
  logic [RW-1:0] iss_dst, iss_srca, iss_srcb;
  logic [1:0] disp_valid, disp_ready;
  logic [2*OW-1:0] disp_op;
  logic [2*TW-1:0] disp_tag;
  logic [2*DW-1:0] disp_a, disp_b;
  logic [1:0] done_valid, done_ready;
  logic [2*TW-1:0] done_tag;
  logic [2*DW-1:0] done_value;
  logic cdb_valid;
  logic [TW-1:0] cdb_tag;
  logic [DW-1:0] cdb_value;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rs_sched dut (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_cls(iss_cls), .iss_op(iss_op),
    .iss_dst(iss_dst), .iss_srca(iss_srca), .iss_srcb(iss_srcb),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_op(disp_op), .disp_tag(disp_tag),
    .disp_a(disp_a), .disp_b(disp_b),
    .done_valid(done_valid), .done_ready(done_ready), .done_tag(done_tag), .done_value(done_value),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value)
  );

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    iss_valid = 0; iss_cls = 0; iss_op = 0; iss_dst = 0; iss_srca = 0; iss_srcb = 0;
    disp_ready = 0; done_valid = 0; done_tag = 0; done_value = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic issue(input int cls, input int opc, input int dst, input int sa, input int sb);
    @(negedge clk);
    iss_cls = cls[0]; iss_op = OW'(opc); iss_dst = RW'(dst);
    iss_srca = RW'(sa); iss_srcb = RW'(sb); iss_valid = 1'b1;
    #1;
    while (!iss_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1 iss_valid = 1'b0;
  endtask

  task automatic take(input int cls, input int tag, input int opc, input int a, input int b, input string rq);
    @(negedge clk);
    #1;
    chk(rq, "disp_valid", 32'(disp_valid[cls]), 1);
    chk(rq, "disp_tag", 32'(disp_tag[cls*TW +: TW]), tag);
    chk(rq, "disp_op", 32'(disp_op[cls*OW +: OW]), opc);
    chk(rq, "disp_a", 32'(disp_a[cls*DW +: DW]), a);
    chk(rq, "disp_b", 32'(disp_b[cls*DW +: DW]), b);
    disp_ready[cls] = 1'b1;
    @(posedge clk);
    #1 disp_ready[cls] = 1'b0;
  endtask

  // returns in the broadcast cycle of the result
  task automatic finish_op(input int cls, input int tag, input int val);
    @(negedge clk);
    done_valid[cls] = 1'b1;
    done_tag[cls*TW +: TW] = TW'(tag);
    done_value[cls*DW +: DW] = DW'(val);
    #1;
    while (!done_ready[cls]) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1 done_valid[cls] = 1'b0;
    chk("R9", "cdb_valid", 32'(cdb_valid), 1);
    chk("R9", "cdb_tag", 32'(cdb_tag), tag);
    chk("R9", "cdb_value", 32'(cdb_value), val);
  endtask

  task automatic peek_disp(input int cls, input int expv, input string rq);
    @(negedge clk);
    #1 chk(rq, "disp_valid", 32'(disp_valid[cls]), expv);
  endtask

  task automatic peek_ready(input int cls, input int expv, input string rq);
    @(negedge clk);
    iss_cls = cls[0];
    #1 chk(rq, "iss_ready", 32'(iss_ready), expv);
  endtask

  task automatic t_reset();
    do_reset();
    peek_ready(0, 1, "R1");
    peek_ready(1, 1, "R1");
    chk("R1", "disp_valid", 32'(disp_valid), 0);
    chk("R1", "cdb_valid", 32'(cdb_valid), 0);
    chk("R1", "done_ready", 32'(done_ready), 0);
  endtask

  task automatic t_basic();
    do_reset();
    issue(0, 3, 5, 1, 2);
    take(0, 0, 3, 1, 2, "R1");       // reset values r1=1, r2=2
    finish_op(0, 0, 16'h0100);
    @(posedge clk);                   // broadcast edge
    issue(0, 4, 6, 5, 5);
    take(0, 0, 4, 16'h0100, 16'h0100, "R12"); // station 0 reused; R2 copy of updated r5
  endtask

  task automatic t_wait();
    do_reset();
    issue(0, 1, 3, 0, 0);
    issue(0, 2, 4, 3, 4);
    take(0, 0, 1, 0, 0, "R2");
    peek_disp(0, 0, "R3");
    finish_op(0, 0, 16'h0055);
    @(posedge clk);
    take(0, 1, 2, 16'h0055, 4, "R3");
  endtask

  task automatic t_waw();
    do_reset();
    issue(0, 1, 6, 0, 0);
    issue(0, 2, 6, 1, 1);
    issue(1, 3, 7, 6, 0);
    take(0, 0, 1, 0, 0, "R6");
    take(0, 1, 2, 1, 1, "R6");
    finish_op(0, 0, 16'h00AA);
    @(posedge clk);
    peek_disp(1, 0, "R4");
    finish_op(0, 1, 16'h00BB);
    @(posedge clk);
    take(1, 2, 3, 16'h00BB, 0, "R4");
    finish_op(1, 2, 16'h0011);
    @(posedge clk);
    issue(0, 5, 1, 6, 7);
    take(0, 0, 5, 16'h00BB, 16'h0011, "R4");
  endtask

  task automatic t_bypass();
    do_reset();
    issue(0, 1, 2, 0, 0);
    take(0, 0, 1, 0, 0, "R2");
    finish_op(0, 0, 16'h0077);
    issue(0, 6, 3, 2, 1);             // accepted on the broadcast edge
    take(0, 1, 6, 16'h0077, 1, "R5");
  endtask

  task automatic t_memorder();
    do_reset();
    issue(0, 1, 3, 0, 0);
    issue(1, 2, 1, 3, 0);
    issue(1, 3, 2, 5, 5);
    peek_ready(1, 0, "R10");
    chk("R7", "disp_valid mem", 32'(disp_valid[1]), 0);
    take(0, 0, 1, 0, 0, "R2");
    finish_op(0, 0, 16'h0033);
    @(posedge clk);
    take(1, 2, 2, 16'h0033, 0, "R7");
    take(1, 3, 3, 5, 5, "R7");
  endtask

  task automatic t_prio();
    do_reset();
    issue(0, 1, 1, 1, 1);
    issue(0, 2, 2, 2, 2);
    issue(1, 3, 3, 3, 3);
    take(0, 0, 1, 1, 1, "R6");
    take(0, 1, 2, 2, 2, "R6");
    take(1, 2, 3, 3, 3, "R2");
    @(negedge clk);
    done_valid = 2'b11;
    done_tag = {2'd2, 2'd0};
    done_value = {16'h0222, 16'h0111};
    #1 chk("R8", "done_ready both", 32'(done_ready), 2'b01);
    @(posedge clk);
    #1 done_valid[0] = 1'b0;
    chk("R8", "cdb_tag first", 32'(cdb_tag), 0);
    chk("R8", "cdb_value first", 32'(cdb_value), 16'h0111);
    @(negedge clk);
    #1 chk("R8", "done_ready loser", 32'(done_ready), 2'b10);
    @(posedge clk);
    #1 done_valid = 2'b00;
    chk("R8", "cdb_tag second", 32'(cdb_tag), 2);
    chk("R8", "cdb_value second", 32'(cdb_value), 16'h0222);
  endtask

  task automatic t_hold();
    do_reset();
    issue(1, 1, 4, 0, 0);
    take(1, 2, 1, 0, 0, "R2");
    issue(0, 2, 5, 4, 0);
    issue(0, 3, 6, 1, 1);
    @(negedge clk);
    #1 chk("R11", "offered tag", 32'(disp_tag[TW-1:0]), 1);
    peek_ready(0, 0, "R10");
    finish_op(1, 2, 16'h0044);
    @(posedge clk);                   // station 0 wakes here
    @(negedge clk);
    #1 chk("R11", "held valid", 32'(disp_valid[0]), 1);
    chk("R11", "held tag", 32'(disp_tag[TW-1:0]), 1);
    take(0, 1, 3, 1, 1, "R11");
    take(0, 0, 2, 16'h0044, 0, "R3");
    peek_ready(0, 0, "R10");
    finish_op(0, 1, 16'h0009);
    chk("R12", "iss_ready in broadcast cycle", 32'(iss_ready), 0);
    @(posedge clk);
    peek_ready(0, 1, "R12");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_wait();
    t_waw();
    t_bypass();
    t_memorder();
    t_prio();
    t_hold();
    repeat (2) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule